// File: doc/BRIEF.md
# Parallel Programming Load Decoder

This block is the device-side front end of a byte-wide parallel programming port. An external programmer places a byte on an 8-bit bus, sets a 2-bit action code and a byte-half select, and then pulses a strobe line. The block brings the strobe into the system clock domain, finds its rising edge, and on that edge loads the bus byte into one of three registers. The address register and the data register are each 16 bits wide and are filled one byte at a time. The command register is 8 bits wide.

The latched command byte is decoded into a one-hot set of operation requests. A byte outside the known set raises an invalid flag instead. After each completed load, a one-cycle done pulse tells downstream logic that it may start the decoded operation. The memory arrays, write timing, high-voltage sensing and read-back path lie outside this block.

Top module: `ppl_load_decoder`

## Requirements
- R1: When the action code `actSel` is 2'b00 at a strobe rising edge, the bus byte loads into the address register. It goes to bits [15:8] when `byteSel` is 1 and to bits [7:0] when `byteSel` is 0. The other byte is kept.
- R2: When the action code is 2'b01 at a strobe rising edge, the bus byte loads into the data register. It goes to the high byte when `byteSel` is 1 and to the low byte when `byteSel` is 0. The other byte is kept.
- R3: When the action code is 2'b10 at a strobe rising edge, the bus byte loads into the command register, whatever the value of `byteSel`.
- R4: When the action code is 2'b11, a strobe pulse changes neither the address, the data nor the command outputs, and produces no `loadDone` pulse.
- R5: The write commands decode onto `opReq` as follows: 8'h80 gives bit 0 (erase), 8'h40 gives bit 1 (fuse write), 8'h20 gives bit 2 (lock write), 8'h10 gives bit 3 (flash write) and 8'h11 gives bit 4 (EEPROM write).
- R6: The read commands decode onto `opReq` as follows: 8'h08 gives bit 5 (signature/calibration read), 8'h04 gives bit 6 (fuse/lock read), 8'h02 gives bit 7 (flash read) and 8'h03 gives bit 8 (EEPROM read). At most one bit of `opReq` is ever set.
- R7: Any other latched command byte sets `cmdInvalid` and leaves `opReq` at zero.
- R8: The strobe passes through a two-stage synchroniser. A load happens once per pulse, on the rising edge only. Holding the strobe high causes no further loads. The outputs update on the third rising clock edge after the strobe rises.
- R9: While `rstN` is low, `addrOut` and `dataOut` are 0, `opReq` is 0, `cmdInvalid` is 0 and `loadDone` is 0. No command is considered loaded after reset.
- R10: `loadDone` is high for exactly one cycle for each load, in the same cycle that the loaded register shows its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobeIn | input | 1 | Asynchronous load strobe from the programmer |
| actSel | input | 2 | Action code: 00 address, 01 data, 10 command, 11 idle |
| byteSel | input | 1 | 1 selects the high byte, 0 selects the low byte |
| busIn | input | 8 | Byte to load |
| addrOut | output | 16 | Assembled address |
| dataOut | output | 16 | Assembled data word |
| opReq | output | 9 | One-hot decoded operation request |
| cmdInvalid | output | 1 | The latched command byte is not a known encoding |
| loadDone | output | 1 | One-cycle pulse after each completed load |

## Verification
If the edge detector held wrong state, it would show up as a missing or repeated `loadDone` within three cycles of a strobe edge. A long strobe pulse would then show up as extra loads. A wrong byte-half or action steer would corrupt the other half of `addrOut` or `dataOut`, and this is visible on the very next load. A fault in the decode table appears at once as a wrong `opReq` bit, or as a wrong `cmdInvalid`, in the cycle that `loadDone` marks. A command register that is set wrongly at reset would show as a nonzero `opReq` or `cmdInvalid` before any command has been loaded.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
  localparam int BUS_W = 8;
  localparam int WORD_W = 2 * BUS_W;
  localparam int OP_N = 9;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ACT_ADDR = 2'b00,
    ACT_DATA = 2'b01,
    ACT_CMD  = 2'b10,
    ACT_IDLE = 2'b11
  } action_e;

  // index 0 is the rightmost entry
  localparam logic [OP_N-1:0][BUS_W-1:0] CMD_CODES = {
    8'h03, 8'h02, 8'h04, 8'h08, 8'h11, 8'h10, 8'h20, 8'h40, 8'h80
  };

  typedef struct packed {
    logic addrLo;
    logic addrHi;
    logic dataLo;
    logic dataHi;
    logic cmd;
  } load_stb_t;
endpackage

// File: rtl/ppl_ctrl.sv
module ppl_ctrl
  import ppl_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      strobeIn,
  input  logic [1:0] actSel,
  input  logic      byteSel,
  output load_stb_t stb,
  output logic      loadDone
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;
  logic rise;
  action_e act;

  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= strobeIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign act  = action_e'(actSel);

  always_comb begin
    stb = '0;
    if (rise) begin
      unique case (act)
        ACT_ADDR: begin
          stb.addrHi = byteSel;
          stb.addrLo = ~byteSel;
        end
        ACT_DATA: begin
          stb.dataHi = byteSel;
          stb.dataLo = ~byteSel;
        end
        ACT_CMD:  stb.cmd = 1'b1;
        default:  stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadDone <= 1'b0;
    else       loadDone <= |stb;
  end
endmodule

// File: rtl/ppl_datapath.sv
module ppl_datapath
  import ppl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  load_stb_t         stb,
  input  logic [BUS_W-1:0]  busIn,
  output logic [WORD_W-1:0] addrOut,
  output logic [WORD_W-1:0] dataOut,
  output logic [OP_N-1:0]   opReq,
  output logic              cmdInvalid
);
  logic [BUS_W-1:0] cmdQ;
  logic cmdLoadedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut    <= '0;
      dataOut    <= '0;
      cmdQ       <= '0;
      cmdLoadedQ <= 1'b0;
    end else begin
      if (stb.addrLo) addrOut[BUS_W-1:0]      <= busIn;
      if (stb.addrHi) addrOut[WORD_W-1:BUS_W] <= busIn;
      if (stb.dataLo) dataOut[BUS_W-1:0]      <= busIn;
      if (stb.dataHi) dataOut[WORD_W-1:BUS_W] <= busIn;
      if (stb.cmd) begin
        cmdQ       <= busIn;
        cmdLoadedQ <= 1'b1;
      end
    end
  end

  genvar i;
  generate
    for (i = 0; i < OP_N; i++) begin : g_dec
      assign opReq[i] = cmdLoadedQ && (cmdQ == CMD_CODES[i]);
    end
  endgenerate

  assign cmdInvalid = cmdLoadedQ && !(|opReq);
endmodule

// File: rtl/ppl_load_decoder.sv
module ppl_load_decoder
  import ppl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic [1:0]        actSel,
  input  logic              byteSel,
  input  logic [BUS_W-1:0]  busIn,
  output logic [WORD_W-1:0] addrOut,
  output logic [WORD_W-1:0] dataOut,
  output logic [OP_N-1:0]   opReq,
  output logic              cmdInvalid,
  output logic              loadDone
);
  load_stb_t stb;

  ppl_ctrl #(.STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobeIn (strobeIn),
    .actSel   (actSel),
    .byteSel  (byteSel),
    .stb      (stb),
    .loadDone (loadDone)
  );

  ppl_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busIn      (busIn),
    .addrOut    (addrOut),
    .dataOut    (dataOut),
    .opReq      (opReq),
    .cmdInvalid (cmdInvalid)
  );
endmodule

// File: rtl/ppl_load_decoder_chk.sv
module ppl_load_decoder_chk
  import ppl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] addrOut,
  input logic [WORD_W-1:0] dataOut,
  input logic [OP_N-1:0]   opReq,
  input logic              cmdInvalid,
  input logic              loadDone
);
  // R6: never more than one request
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(opReq));

  // R7: invalid flag and any request are exclusive
  p_inv_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdInvalid && (|opReq)));

  // R10: done is a single-cycle pulse
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  // R1: address moves only in a load cycle
  p_addr_on_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(addrOut) |-> loadDone);

  // R2: data moves only in a load cycle
  p_data_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> loadDone);

  // R3: decoded command moves only in a load cycle
  p_cmd_on_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(opReq) && $stable(cmdInvalid)) |-> loadDone);
endmodule

bind ppl_load_decoder ppl_load_decoder_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .addrOut    (addrOut),
  .dataOut    (dataOut),
  .opReq      (opReq),
  .cmdInvalid (cmdInvalid),
  .loadDone   (loadDone)
);

// File: tb/ppl_load_decoder_tb.sv
module ppl_load_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeIn = 1'b0;
  logic [1:0] actSel = 2'b11;
  logic byteSel = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic [15:0] addrOut, dataOut;
  logic [8:0] opReq;
  logic cmdInvalid, loadDone;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit finished = 0;

  logic [15:0] expAddr = 16'h0;
  logic [15:0] expData = 16'h0;

  always #10 clk = ~clk;

  ppl_load_decoder dut_i (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .actSel(actSel),
    .byteSel(byteSel), .busIn(busIn), .addrOut(addrOut), .dataOut(dataOut),
    .opReq(opReq), .cmdInvalid(cmdInvalid), .loadDone(loadDone)
  );

  always @(negedge clk) if (rstN && loadDone) pulses++;

  // {act, byteSel, bus, expected opReq, expected cmdInvalid}
  localparam int N_VEC = 20;
  localparam logic [20:0] VEC [N_VEC] = '{
    {2'b00, 1'b0, 8'h34, 9'h000, 1'b0},
    {2'b00, 1'b1, 8'h12, 9'h000, 1'b0},
    {2'b01, 1'b0, 8'hCD, 9'h000, 1'b0},
    {2'b01, 1'b1, 8'hAB, 9'h000, 1'b0},
    {2'b10, 1'b0, 8'h80, 9'h001, 1'b0},
    {2'b10, 1'b1, 8'h40, 9'h002, 1'b0},
    {2'b10, 1'b0, 8'h20, 9'h004, 1'b0},
    {2'b10, 1'b0, 8'h10, 9'h008, 1'b0},
    {2'b10, 1'b0, 8'h11, 9'h010, 1'b0},
    {2'b10, 1'b0, 8'h08, 9'h020, 1'b0},
    {2'b10, 1'b1, 8'h04, 9'h040, 1'b0},
    {2'b10, 1'b0, 8'h02, 9'h080, 1'b0},
    {2'b10, 1'b0, 8'h03, 9'h100, 1'b0},
    {2'b10, 1'b0, 8'hFF, 9'h000, 1'b1},
    {2'b11, 1'b0, 8'h55, 9'h000, 1'b1},
    {2'b10, 1'b1, 8'h00, 9'h000, 1'b1},
    {2'b10, 1'b0, 8'h12, 9'h000, 1'b1},
    {2'b10, 1'b0, 8'h10, 9'h008, 1'b0},
    {2'b00, 1'b0, 8'hFF, 9'h008, 1'b0},
    {2'b11, 1'b1, 8'h00, 9'h008, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive one pulse; sample in the cycle the outputs update
  task automatic pulse(input logic [1:0] a, input logic b, input logic [7:0] d);
    @(negedge clk);
    actSel = a; byteSel = b; busIn = d; strobeIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_strobe();
    strobeIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "addr", addrOut, 0);
    chk("R9", "data", dataOut, 0);
    chk("R9", "opReq", opReq, 0);
    chk("R9", "cmdInvalid", cmdInvalid, 0);
    chk("R9", "loadDone", loadDone, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "opReq after release", opReq, 0);
    chk("R9", "cmdInvalid after release", cmdInvalid, 0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [1:0] a; logic b; logic [7:0] d; logic [8:0] eo; logic ei;
      {a, b, d, eo, ei} = VEC[i];
      if (a == 2'b00) begin
        if (b) expAddr[15:8] = d; else expAddr[7:0] = d;
      end else if (a == 2'b01) begin
        if (b) expData[15:8] = d; else expData[7:0] = d;
      end
      pulse(a, b, d);
      // R1/R2 address and data, R4 idle leaves both alone
      chk(a == 2'b01 ? "R2" : (a == 2'b11 ? "R4" : "R1"), "addr", addrOut, expAddr);
      chk(a == 2'b00 ? "R1" : (a == 2'b11 ? "R4" : "R2"), "data", dataOut, expData);
      // R5/R6/R7 decode, R3 command load
      chk(ei ? "R7" : (eo > 9'h010 ? "R6" : "R5"), "opReq", opReq, eo);
      chk(a == 2'b10 ? "R3" : "R7", "cmdInvalid", cmdInvalid, ei);
      // R10 done pulse coincides with update; R4 none on idle
      chk(a == 2'b11 ? "R4" : "R10", "loadDone", loadDone, a != 2'b11);
      @(negedge clk);
      chk("R10", "loadDone next cycle", loadDone, 0);
      release_strobe();
    end

    // R8: long strobe gives exactly one load
    p0 = pulses;
    expAddr[7:0] = 8'h5A;
    pulse(2'b00, 1'b0, 8'h5A);
    repeat (30) @(negedge clk);
    chk("R8", "pulses for held strobe", pulses - p0, 1);
    chk("R8", "addr after held strobe", addrOut, expAddr);
    // R8: bus change while held high has no effect
    busIn = 8'hC3;
    repeat (10) @(negedge clk);
    chk("R8", "addr unchanged while held", addrOut, expAddr);
    release_strobe();

    // R8: latency, not updated after only two edges
    @(negedge clk);
    actSel = 2'b01; byteSel = 1'b0; busIn = 8'h77; strobeIn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8", "data before third edge", dataOut, expData);
    @(negedge clk);
    expData[7:0] = 8'h77;
    chk("R8", "data after third edge", dataOut, expData);
    release_strobe();

    // R9: reset mid-stream clears everything
    pulse(2'b10, 1'b0, 8'h80);
    release_strobe();
    rstN = 1'b0;
    @(negedge clk);
    chk("R9", "addr in reset", addrOut, 0);
    chk("R9", "data in reset", dataOut, 0);
    chk("R9", "opReq in reset", opReq, 0);
    chk("R9", "cmdInvalid in reset", cmdInvalid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "no command after reset", {cmdInvalid, opReq}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule